// File: doc/BRIEF.md
# LIN Bus Wake-up Detector

This block watches the synchronised receive level of a LIN bus while the device rests in one of its two low-power modes. In both modes the transmit driver is held off and only the receiver remains active. A wake-up counts only when the bus has been dominant (low) for at least a minimum number of clock samples and then returns recessive (high). Shorter dominant glitches are discarded.

What a qualified wake-up does depends on the mode. In stop mode it raises a level interrupt, provided the interrupt mask bit allows it. In sleep mode it emits a one-cycle request to the system reset generator. Both kinds of event set a sticky wake-up source flag. A read strobe of the interrupt-source register clears this flag and the interrupt. If the receive-only bit is set while in stop mode, bus wake-up is disabled.

Detection is armed only after the bus has been seen recessive in the current mode. A dominant level that was already present when the mode was entered can therefore never trigger a wake-up.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset, `tx_en`, `wake_flag`, `wake_irq` and `wake_rst_req` are all 0.
- R2: Mode encoding on `mode_sel` is 2'b00 run, 2'b01 stop, 2'b10 sleep, and 2'b11 is treated as run. One cycle after a stop or sleep sample, `tx_en` is 0. One cycle after a run sample, `tx_en` is 1.
- R3: A dominant run (`rxd_sync`=0) of fewer than MIN_DOM consecutive samples, followed by a recessive sample, produces no wake-up.
- R4: A dominant run of at least MIN_DOM consecutive samples, followed by a recessive sample, is a wake-up in a low-power mode. `wake_flag` reads 1 in the cycle after the edge that samples the recessive level.
- R5: A wake-up in stop mode sets `wake_irq` in the same cycle as the flag, but only when `irq_mask_en` is 1. With `irq_mask_en` at 0, only the flag is set.
- R6: A wake-up in sleep mode drives `wake_rst_req` high for exactly one cycle, aligned with the flag, and leaves `wake_irq` low.
- R7: In stop mode with `rx_only`=1, no wake-up is recorded. In sleep mode, `rx_only` has no effect.
- R8: In run mode (2'b00 or 2'b11), no dominant-then-recessive pattern produces a wake-up.
- R9: After a mode change, a wake-up is only accepted once at least one recessive sample has been taken in the new mode. A dominant run that spans the mode entry is ignored.
- R10: `wake_flag` and `wake_irq` stay set until an `isr_read` strobe clears them. If a wake-up and a read fall in the same cycle, the wake-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Power mode: 00 run, 01 stop, 10 sleep, 11 run |
| rx_only | input | 1 | Receive-only bit; disables wake-up in stop mode |
| irq_mask_en | input | 1 | Enables the stop-mode wake-up interrupt |
| rxd_sync | input | 1 | Synchronised bus receive level, 0 = dominant |
| isr_read | input | 1 | Interrupt-source register read strobe |
| tx_en | output | 1 | Transmit driver enable, off in low-power modes |
| wake_flag | output | 1 | Sticky wake-up source flag |
| wake_irq | output | 1 | Stop-mode wake-up interrupt, level |
| wake_rst_req | output | 1 | Sleep-mode wake-up reset request, one-cycle pulse |

## Verification
The hardest case to reach from the ports is the arming rule. It needs a dominant level that is already present as a low-power mode begins, lasts well past the filter time, and ends in a clean rising edge that must still be rejected. The bench gets there by switching `mode_sel` from run to stop on the same cycle it drives the bus dominant. It then confirms that the next properly framed pulse is accepted. A sweep of every dominant length from one sample up to two past the threshold, across every mode, mask and receive-only combination, covers the filter boundary exactly.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_STOP  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_RSVD  = 2'b11
  } pwr_mode_e;

  function automatic logic is_low_power(input logic [1:0] m);
    return (m == PM_STOP) || (m == PM_SLEEP);
  endfunction

endpackage

// File: rtl/lin_dom_filter.sv
module lin_dom_filter #(
  parameter int unsigned MIN_DOM = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic qualified,
  output logic rise
);
  localparam int unsigned CNT_W = $clog2(MIN_DOM + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_DOM);

  logic [CNT_W-1:0] dom_cnt;
  logic             rxd_q;

  // saturating count of consecutive dominant samples
  always_ff @(posedge clk) begin
    if (rst) begin
      dom_cnt <= '0;
      rxd_q   <= 1'b1;
    end else begin
      rxd_q <= rxd;
      if (rxd)
        dom_cnt <= '0;
      else if (dom_cnt != CNT_MAX)
        dom_cnt <= dom_cnt + CNT_W'(1);
    end
  end

  assign qualified = (dom_cnt == CNT_MAX);
  assign rise      = rxd & ~rxd_q;
endmodule

// File: rtl/lin_wake_arm.sv
module lin_wake_arm
  import lin_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       rxd,
  output logic       armed,
  output logic       steady
);
  logic [1:0] mode_q;

  // arm only after a recessive sample taken in an unchanged low-power mode
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_RUN;
      armed  <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      if (!is_low_power(mode_sel) || (mode_sel != mode_q))
        armed <= 1'b0;
      else if (rxd)
        armed <= 1'b1;
    end
  end

  assign steady = (mode_sel == mode_q);
endmodule

// File: rtl/lin_wake_route.sv
module lin_wake_route
  import lin_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evt,
  input  logic [1:0] mode_sel,
  input  logic       irq_mask_en,
  input  logic       isr_read,
  output logic       tx_en,
  output logic       wake_flag,
  output logic       wake_irq,
  output logic       wake_rst_req
);
  logic in_stop, in_sleep;
  assign in_stop  = (mode_sel == PM_STOP);
  assign in_sleep = (mode_sel == PM_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en        <= 1'b0;
      wake_flag    <= 1'b0;
      wake_irq     <= 1'b0;
      wake_rst_req <= 1'b0;
    end else begin
      tx_en        <= ~is_low_power(mode_sel);
      wake_rst_req <= evt & in_sleep;
      if (evt)
        wake_flag <= 1'b1;
      else if (isr_read)
        wake_flag <= 1'b0;
      if (evt && in_stop && irq_mask_en)
        wake_irq <= 1'b1;
      else if (isr_read)
        wake_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect
  import lin_wake_pkg::*;
#(
  parameter int unsigned MIN_DOM = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       rx_only,
  input  logic       irq_mask_en,
  input  logic       rxd_sync,
  input  logic       isr_read,
  output logic       tx_en,
  output logic       wake_flag,
  output logic       wake_irq,
  output logic       wake_rst_req
);
  logic qualified, rise, armed, steady, mode_ok, evt;

  lin_dom_filter #(.MIN_DOM(MIN_DOM)) u_filter (
    .clk       (clk),
    .rst       (rst),
    .rxd       (rxd_sync),
    .qualified (qualified),
    .rise      (rise)
  );

  lin_wake_arm u_arm (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .rxd      (rxd_sync),
    .armed    (armed),
    .steady   (steady)
  );

  // receive-only blocks wake-up in stop mode only
  assign mode_ok = (mode_sel == PM_SLEEP) || ((mode_sel == PM_STOP) && !rx_only);
  assign evt     = armed & steady & rise & qualified & mode_ok;

  lin_wake_route u_route (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .mode_sel     (mode_sel),
    .irq_mask_en  (irq_mask_en),
    .isr_read     (isr_read),
    .tx_en        (tx_en),
    .wake_flag    (wake_flag),
    .wake_irq     (wake_irq),
    .wake_rst_req (wake_rst_req)
  );
endmodule

// File: rtl/lin_wake_detect_chk.sv
module lin_wake_detect_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       rx_only,
  input logic       irq_mask_en,
  input logic       rxd_sync,
  input logic       tx_en,
  input logic       wake_flag,
  input logic       wake_irq,
  input logic       wake_rst_req
);
  p_tx_off_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 || mode_sel == 2'b10) |=> !tx_en);

  p_rise_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> ($past(rxd_sync) && !$past(rxd_sync, 2)));

  p_irq_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> ($past(mode_sel) == 2'b01 && $past(irq_mask_en)));

  p_rst_sleep_r6: assert property (@(posedge clk) disable iff (rst)
    wake_rst_req |-> ($past(mode_sel) == 2'b10 && wake_flag));

  p_rst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wake_rst_req |=> !wake_rst_req);

  p_rxonly_stop_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> !($past(mode_sel) == 2'b01 && $past(rx_only)));

  p_lowpower_only_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> ($past(mode_sel) == 2'b01 || $past(mode_sel) == 2'b10));
endmodule

bind lin_wake_detect lin_wake_detect_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_sel     (mode_sel),
  .rx_only      (rx_only),
  .irq_mask_en  (irq_mask_en),
  .rxd_sync     (rxd_sync),
  .tx_en        (tx_en),
  .wake_flag    (wake_flag),
  .wake_irq     (wake_irq),
  .wake_rst_req (wake_rst_req)
);

// File: tb/lin_wake_detect_bench.sv
module lin_wake_detect_bench;
  localparam int MIN_DOM = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       rx_only = 1'b0;
  logic       irq_mask_en = 1'b0;
  logic       rxd_sync = 1'b1;
  logic       isr_read = 1'b0;
  logic       tx_en, wake_flag, wake_irq, wake_rst_req;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  lin_wake_detect #(.MIN_DOM(MIN_DOM)) u_lin_wake_detect (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .rx_only      (rx_only),
    .irq_mask_en  (irq_mask_en),
    .rxd_sync     (rxd_sync),
    .isr_read     (isr_read),
    .tx_en        (tx_en),
    .wake_flag    (wake_flag),
    .wake_irq     (wake_irq),
    .wake_rst_req (wake_rst_req)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one framed pulse in the given configuration; expectations derived from R2..R8
  task automatic run_case(input logic [1:0] m, input logic rxo, input logic msk, input int len);
    logic lp, wake, exp_irq, exp_rst;
    lp      = (m == 2'b01) || (m == 2'b10);
    wake    = (len >= MIN_DOM) && ((m == 2'b10) || (m == 2'b01 && !rxo));
    exp_irq = wake && (m == 2'b01) && msk;
    exp_rst = wake && (m == 2'b10);
    @(negedge clk);
    mode_sel = m; rx_only = rxo; irq_mask_en = msk; rxd_sync = 1'b1; isr_read = 1'b1;
    @(negedge clk);
    isr_read = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "tx_en", tx_en, !lp);
    chk("R10", "flag cleared", wake_flag, 1'b0);
    for (int i = 0; i < len; i++) begin
      rxd_sync = 1'b0;
      @(negedge clk);
    end
    rxd_sync = 1'b1;
    @(negedge clk);
    if (len < MIN_DOM) chk("R3", "short pulse flag", wake_flag, 1'b0);
    else if (!lp)      chk("R8", "run mode flag", wake_flag, 1'b0);
    else if (m == 2'b01 && rxo) chk("R7", "rx_only stop flag", wake_flag, 1'b0);
    else               chk("R4", "wake flag", wake_flag, 1'b1);
    chk("R5", "wake_irq", wake_irq, exp_irq);
    chk("R6", "wake_rst_req", wake_rst_req, exp_rst);
    @(negedge clk);
    chk("R6", "rst pulse ended", wake_rst_req, 1'b0);
    chk("R10", "flag held", wake_flag, wake);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1", "tx_en", tx_en, 1'b0);
    chk("R1", "wake_flag", wake_flag, 1'b0);
    chk("R1", "wake_irq", wake_irq, 1'b0);
    chk("R1", "wake_rst_req", wake_rst_req, 1'b0);
    rst = 1'b0;

    // sweep modes x rx_only x mask x dominant length
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 2; r++)
        for (int k = 0; k < 2; k++)
          for (int len = 1; len <= MIN_DOM + 2; len++)
            run_case(m[1:0], r[0], k[0], len);

    // R9: dominant already present when entering stop is not accepted
    @(negedge clk);
    mode_sel = 2'b00; rx_only = 1'b0; irq_mask_en = 1'b1; rxd_sync = 1'b1; isr_read = 1'b1;
    @(negedge clk);
    isr_read = 1'b0;
    @(negedge clk);
    mode_sel = 2'b01; rxd_sync = 1'b0;
    repeat (MIN_DOM + 3) @(negedge clk);
    rxd_sync = 1'b1;
    @(negedge clk);
    chk("R9", "unarmed flag", wake_flag, 1'b0);
    chk("R9", "unarmed irq", wake_irq, 1'b0);
    @(negedge clk);
    rxd_sync = 1'b0;
    repeat (MIN_DOM) @(negedge clk);
    rxd_sync = 1'b1;
    @(negedge clk);
    chk("R9", "armed flag", wake_flag, 1'b1);
    chk("R9", "armed irq", wake_irq, 1'b1);

    // R10: read coinciding with a new wake-up keeps the flag
    rxd_sync = 1'b0;
    repeat (MIN_DOM) @(negedge clk);
    rxd_sync = 1'b1; isr_read = 1'b1;
    @(negedge clk);
    isr_read = 1'b0;
    chk("R10", "set beats clear flag", wake_flag, 1'b1);
    chk("R10", "set beats clear irq", wake_irq, 1'b1);
    isr_read = 1'b1;
    @(negedge clk);
    isr_read = 1'b0;
    chk("R10", "read clears flag", wake_flag, 1'b0);
    chk("R10", "read clears irq", wake_irq, 1'b0);

    // R2: reserved encoding behaves as run
    mode_sel = 2'b11;
    @(negedge clk);
    chk("R2", "tx_en reserved mode", tx_en, 1'b1);
    mode_sel = 2'b10;
    @(negedge clk);
    chk("R2", "tx_en sleep", tx_en, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule